// File: doc/BRIEF.md
# Hart Cycle and Retired-Instruction Counter Unit

This block keeps two 64-bit event counters for one processor hart. One counts clock cycles. The other counts retired instructions. Software reaches both through a 12-bit control-register address port. The port also gives read access to a 64-bit real-time value that arrives from outside the block. Read data and the illegal-access flag are combinational, so they are valid in the same cycle as the strobe. Counter updates take effect at the next rising clock edge.

The parameter `XLEN` sets the register width to 32 or 64. When it is 32, each counter is seen as two 32-bit windows, and the upper window sits at a separate high address. The machine-level addresses accept writes and are open only at machine privilege. The user-level aliases are read-only and are open only at user privilege. Any access that fails decoding, privilege or write permission raises the illegal flag and changes nothing. A software write to a counter replaces that cycle's automatic count.

Top module: `perf_csr_unit`

## Requirements
- R1: After reset both counters are zero.
- R2: The cycle counter increases by one on every clock edge unless software writes it in that cycle, and it wraps modulo 2^64.
- R3: The retired-instruction counter increases by one on each edge where `retire` is high, and holds its value otherwise.
- R4: Address 0xB00 reads and writes the low `XLEN` bits of the cycle counter. Address 0xB02 does the same for the retired-instruction counter.
- R5: When `XLEN` is 32, addresses 0xB80 and 0xB82 read and write bits 63..32 of the cycle and retired-instruction counters. A write to one half leaves the other half unchanged. When `XLEN` is 64, every address whose bits 7..4 equal 0x8 is undefined and illegal.
- R6: A legal software write to either counter sets that counter to the merged value at the next edge. No increment is applied in that cycle, and a `retire` pulse in the same cycle is dropped.
- R7: Addresses 0xC00, 0xC01 and 0xC02 read the low `XLEN` bits of the cycle counter, `timeIn` and the retired-instruction counter. When `XLEN` is 32, addresses 0xC80, 0xC81 and 0xC82 read bits 63..32 of the same three values.
- R8: `priv` is encoded as follows: 2'b00 is user, 2'b01 is supervisor, 2'b11 is machine, and 2'b10 matches no level. The 0xBxx addresses are legal only at machine level. The 0xCxx aliases are legal only at user level.
- R9: A write to any 0xCxx alias, including the time alias, is illegal and changes no state.
- R10: `illegal` is high in the same cycle as a read or write strobe that targets an undecoded address or fails a check. `rdData` is zero whenever `rdEn` is low or the access is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csrAddr | input | 12 | Control-register address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | XLEN | Write data |
| priv | input | 2 | Current privilege level (00 user, 01 supervisor, 11 machine) |
| retire | input | 1 | One instruction retired this cycle |
| timeIn | input | 64 | External real-time value |
| rdData | output | XLEN | Read data, zero unless a legal read |
| illegal | output | 1 | Strobed access failed decode, privilege or write check |

## Verification
The counter-step properties assume that the address, strobes and privilege stay stable for the whole cycle and are driven only between edges. The bench meets this by changing every input on the falling edge. The write-landing properties assume that a strobe held for one cycle means a single access. The bench therefore presents one access per cycle, with read and write strobes that can overlap but never repeat the same write across cycles by accident. The sweeps cover all 4096 addresses at all four privilege encodings. They run both widths side by side on the same stimulus, so the checks against the arithmetic model see every decode and gating combination.

// File: rtl/perfcsr_pkg.sv
package perfcsr_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_CYC_LO,
    WIN_CYC_HI,
    WIN_TIM_LO,
    WIN_TIM_HI,
    WIN_INS_LO,
    WIN_INS_HI
  } win_e;

  // Strobes passed from decode/control to the datapath
  typedef struct packed {
    logic cycLoWr;
    logic cycHiWr;
    logic insLoWr;
    logic insHiWr;
    win_e rdWin;
  } ctrlStrobe_t;

  localparam logic [11:0] ADDR_M_CYC    = 12'hB00;
  localparam logic [11:0] ADDR_M_INS    = 12'hB02;
  localparam logic [11:0] ADDR_M_CYC_HI = 12'hB80;
  localparam logic [11:0] ADDR_M_INS_HI = 12'hB82;
  localparam logic [11:0] ADDR_U_CYC    = 12'hC00;
  localparam logic [11:0] ADDR_U_TIM    = 12'hC01;
  localparam logic [11:0] ADDR_U_INS    = 12'hC02;
  localparam logic [11:0] ADDR_U_CYC_HI = 12'hC80;
  localparam logic [11:0] ADDR_U_TIM_HI = 12'hC81;
  localparam logic [11:0] ADDR_U_INS_HI = 12'hC82;

  localparam int CTR_CYC = 0;
  localparam int CTR_INS = 1;
  localparam int NUM_CTR = 2;
  localparam int CTR_W   = 64;

endpackage

// File: rtl/perfcsr_ctrl.sv
module perfcsr_ctrl
  import perfcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0]  csrAddr,
  input  logic         rdEn,
  input  logic         wrEn,
  input  logic [1:0]   priv,
  output ctrlStrobe_t  strobe,
  output logic         illegal
);

  localparam bit HAS_HI = (XLEN == 32);

  win_e win;
  logic known;
  logic isMach;
  logic isHi;
  logic privOk;
  logic roViol;
  logic accOk;
  logic wrOk;

  // Address decode: which window, which privilege class, high-half or not
  always_comb begin
    win    = WIN_NONE;
    known  = 1'b0;
    isMach = 1'b0;
    isHi   = 1'b0;
    case (csrAddr)
      ADDR_M_CYC:    begin win = WIN_CYC_LO; known = 1'b1; isMach = 1'b1; end
      ADDR_M_INS:    begin win = WIN_INS_LO; known = 1'b1; isMach = 1'b1; end
      ADDR_M_CYC_HI: begin win = WIN_CYC_HI; known = 1'b1; isMach = 1'b1; isHi = 1'b1; end
      ADDR_M_INS_HI: begin win = WIN_INS_HI; known = 1'b1; isMach = 1'b1; isHi = 1'b1; end
      ADDR_U_CYC:    begin win = WIN_CYC_LO; known = 1'b1; end
      ADDR_U_TIM:    begin win = WIN_TIM_LO; known = 1'b1; end
      ADDR_U_INS:    begin win = WIN_INS_LO; known = 1'b1; end
      ADDR_U_CYC_HI: begin win = WIN_CYC_HI; known = 1'b1; isHi = 1'b1; end
      ADDR_U_TIM_HI: begin win = WIN_TIM_HI; known = 1'b1; isHi = 1'b1; end
      ADDR_U_INS_HI: begin win = WIN_INS_HI; known = 1'b1; isHi = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    privOk  = isMach ? (priv == PRIV_MACH) : (priv == PRIV_USER);
    roViol  = wrEn && !isMach;
    accOk   = known && (HAS_HI || !isHi) && privOk && !roViol;
    illegal = (rdEn || wrEn) && !accOk;
    wrOk    = wrEn && accOk;
  end

  always_comb begin
    strobe.cycLoWr = wrOk && (win == WIN_CYC_LO);
    strobe.cycHiWr = wrOk && (win == WIN_CYC_HI);
    strobe.insLoWr = wrOk && (win == WIN_INS_LO);
    strobe.insHiWr = wrOk && (win == WIN_INS_HI);
    strobe.rdWin   = (rdEn && accOk) ? win : WIN_NONE;
  end

endmodule

// File: rtl/perfcsr_counter.sv
module perfcsr_counter
  import perfcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             incr,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic [XLEN-1:0]  wrData,
  output logic [CTR_W-1:0] value
);

  logic [CTR_W-1:0] nextVal;

  // A software write takes the place of the increment in its cycle
  generate
    if (XLEN == 32) begin : g_narrow
      always_comb begin
        if (wrHi)      nextVal = {wrData, value[31:0]};
        else if (wrLo) nextVal = {value[CTR_W-1:32], wrData};
        else           nextVal = value + CTR_W'(incr);
      end
    end else begin : g_wide
      always_comb begin
        if (wrLo) nextVal = wrData;
        else      nextVal = value + CTR_W'(incr);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nextVal;
  end

endmodule

// File: rtl/perfcsr_dp.sv
module perfcsr_dp
  import perfcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             incrIns,
  input  ctrlStrobe_t      strobe,
  input  logic [XLEN-1:0]  wrData,
  input  logic [CTR_W-1:0] timeIn,
  output logic [XLEN-1:0]  rdData,
  output logic [CTR_W-1:0] cycVal,
  output logic [CTR_W-1:0] insVal
);

  logic [CTR_W-1:0]   ctrVal [NUM_CTR];
  logic [NUM_CTR-1:0] ctrWrLo;
  logic [NUM_CTR-1:0] ctrWrHi;
  logic [NUM_CTR-1:0] ctrInc;

  assign ctrWrLo = {strobe.insLoWr, strobe.cycLoWr};
  assign ctrWrHi = {strobe.insHiWr, strobe.cycHiWr};
  assign ctrInc  = {incrIns, 1'b1};

  generate
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      perfcsr_counter #(.XLEN(XLEN)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .incr   (ctrInc[k]),
        .wrLo   (ctrWrLo[k]),
        .wrHi   (ctrWrHi[k]),
        .wrData (wrData),
        .value  (ctrVal[k])
      );
    end
  endgenerate

  assign cycVal = ctrVal[CTR_CYC];
  assign insVal = ctrVal[CTR_INS];

  logic [XLEN-1:0] cycLo, cycHi, timLo, timHi, insLo, insHi;

  assign cycLo = cycVal[XLEN-1:0];
  assign timLo = timeIn[XLEN-1:0];
  assign insLo = insVal[XLEN-1:0];

  generate
    if (XLEN == 32) begin : g_hiwin
      assign cycHi = cycVal[CTR_W-1:32];
      assign timHi = timeIn[CTR_W-1:32];
      assign insHi = insVal[CTR_W-1:32];
    end else begin : g_nohiwin
      assign cycHi = '0;
      assign timHi = '0;
      assign insHi = '0;
    end
  endgenerate

  always_comb begin
    case (strobe.rdWin)
      WIN_CYC_LO: rdData = cycLo;
      WIN_CYC_HI: rdData = cycHi;
      WIN_TIM_LO: rdData = timLo;
      WIN_TIM_HI: rdData = timHi;
      WIN_INS_LO: rdData = insLo;
      WIN_INS_HI: rdData = insHi;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/perf_csr_unit.sv
module perf_csr_unit
  import perfcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csrAddr,
  input  logic            rdEn,
  input  logic            wrEn,
  input  logic [XLEN-1:0] wrData,
  input  logic [1:0]      priv,
  input  logic            retire,
  input  logic [63:0]     timeIn,
  output logic [XLEN-1:0] rdData,
  output logic            illegal
);

  ctrlStrobe_t      strobe;
  logic [CTR_W-1:0] cycVal;
  logic [CTR_W-1:0] insVal;

  perfcsr_ctrl #(.XLEN(XLEN)) u_ctrl (
    .csrAddr (csrAddr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .priv    (priv),
    .strobe  (strobe),
    .illegal (illegal)
  );

  perfcsr_dp #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .incrIns (retire),
    .strobe  (strobe),
    .wrData  (wrData),
    .timeIn  (timeIn),
    .rdData  (rdData),
    .cycVal  (cycVal),
    .insVal  (insVal)
  );

endmodule

// File: rtl/perf_csr_unit_chk.sv
module perf_csr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csrAddr,
  input logic            rdEn,
  input logic            wrEn,
  input logic [XLEN-1:0] wrData,
  input logic [1:0]      priv,
  input logic            retire,
  input logic [XLEN-1:0] rdData,
  input logic            illegal,
  input logic [63:0]     cycVal,
  input logic [63:0]     insVal
);

  logic cycWr;
  logic insWr;
  assign cycWr = wrEn && !illegal && ((csrAddr == 12'hB00) || (csrAddr == 12'hB80));
  assign insWr = wrEn && !illegal && ((csrAddr == 12'hB02) || (csrAddr == 12'hB82));

  p_cyc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cycWr |=> cycVal == $past(cycVal) + 64'd1);

  p_ins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!insWr && !retire) |=> $stable(insVal));

  p_ins_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!insWr && retire) |=> insVal == $past(insVal) + 64'd1);

  p_cyc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !illegal && csrAddr == 12'hB00) |=> cycVal[XLEN-1:0] == $past(wrData));

  p_ins_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !illegal && csrAddr == 12'hB02) |=> insVal[XLEN-1:0] == $past(wrData));

  p_mach_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdEn || wrEn) && csrAddr[11:8] == 4'hB && priv != 2'b11) |-> illegal);

  p_user_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && csrAddr[11:8] == 4'hC) |-> illegal);

  p_hi_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((XLEN == 64) && (rdEn || wrEn) && csrAddr[7:4] == 4'h8) |-> illegal);

  p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || !rdEn) |-> rdData == '0);

endmodule

bind perf_csr_unit perf_csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csrAddr (csrAddr),
  .rdEn    (rdEn),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .priv    (priv),
  .retire  (retire),
  .rdData  (rdData),
  .illegal (illegal),
  .cycVal  (cycVal),
  .insVal  (insVal)
);

// File: tb/test_perf_csr_unit.sv
`timescale 1ns/1ps
module test_perf_csr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csrAddr;
  logic        rdEn, wrEn;
  logic [31:0] wd32;
  logic [63:0] wd64;
  logic [1:0]  priv;
  logic        retire;
  logic [63:0] timeIn;
  logic [31:0] rd32;
  logic [63:0] rd64;
  logic        ill32, ill64;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;
  logic [63:0] mCyc32, mIns32, mCyc64, mIns64;

  always #4 clk = ~clk;

  perf_csr_unit #(.XLEN(32)) i_perf_csr_unit (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wd32), .priv(priv), .retire(retire), .timeIn(timeIn),
    .rdData(rd32), .illegal(ill32));

  perf_csr_unit #(.XLEN(64)) i_perf_csr_unit_w64 (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wd64), .priv(priv), .retire(retire), .timeIn(timeIn),
    .rdData(rd64), .illegal(ill64));

  function automatic bit isLegal(input logic [11:0] a, input logic [1:0] p,
                                 input bit wr, input bit narrow);
    bit mach, usr;
    mach = (a == 12'hB00) || (a == 12'hB02) ||
           (narrow && ((a == 12'hB80) || (a == 12'hB82)));
    usr  = (a == 12'hC00) || (a == 12'hC01) || (a == 12'hC02) ||
           (narrow && ((a == 12'hC80) || (a == 12'hC81) || (a == 12'hC82)));
    if (mach) return p == 2'b11;
    if (usr)  return (p == 2'b00) && !wr;
    return 1'b0;
  endfunction

  function automatic logic [63:0] pick(input logic [11:0] a, input logic [63:0] cyc,
                                       input logic [63:0] ins, input logic [63:0] tim,
                                       input bit narrow);
    logic [63:0] lm;
    lm = narrow ? 64'h0000_0000_FFFF_FFFF : '1;
    case (a)
      12'hB00, 12'hC00: return cyc & lm;
      12'hB02, 12'hC02: return ins & lm;
      12'hC01:          return tim & lm;
      12'hB80, 12'hC80: return {32'h0, cyc[63:32]};
      12'hB82, 12'hC82: return {32'h0, ins[63:32]};
      12'hC81:          return {32'h0, tim[63:32]};
      default:          return '0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic upd(inout logic [63:0] cyc, inout logic [63:0] ins,
                     input logic [11:0] a, input bit wrOk, input logic [63:0] d,
                     input bit ret, input bit narrow);
    if (wrOk && a == 12'hB00)      cyc = narrow ? {cyc[63:32], d[31:0]} : d;
    else if (wrOk && a == 12'hB80) cyc = {d[31:0], cyc[31:0]};
    else                           cyc = cyc + 64'd1;
    if (wrOk && a == 12'hB02)      ins = narrow ? {ins[63:32], d[31:0]} : d;
    else if (wrOk && a == 12'hB82) ins = {d[31:0], ins[31:0]};
    else                           ins = ins + 64'(ret);
  endtask

  // Starts and ends at a falling edge; one access per cycle
  task automatic step(input logic [11:0] a, input bit r, input bit w,
                      input logic [31:0] d, input logic [1:0] p, input bit ret,
                      input string req);
    bit l32, l64;
    logic [63:0] e32, e64;
    csrAddr = a; rdEn = r; wrEn = w; wd32 = d; wd64 = {d, d};
    priv = p; retire = ret; timeIn = {~d, d ^ {20'h0, a}};
    #1;
    l32 = isLegal(a, p, w, 1'b1);
    l64 = isLegal(a, p, w, 1'b0);
    e32 = (r && l32) ? pick(a, mCyc32, mIns32, timeIn, 1'b1) : '0;
    e64 = (r && l64) ? pick(a, mCyc64, mIns64, timeIn, 1'b0) : '0;
    check(req, "illegal x32", {63'h0, ill32}, {63'h0, (r || w) && !l32});
    check(req, "rdData x32",  {32'h0, rd32}, e32);
    check(req, "illegal x64", {63'h0, ill64}, {63'h0, (r || w) && !l64});
    check(req, "rdData x64",  rd64, e64);
    @(posedge clk);
    upd(mCyc32, mIns32, a, w && l32, {32'h0, d}, ret, 1'b1);
    upd(mCyc64, mIns64, a, w && l64, {d, d}, ret, 1'b0);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; csrAddr = '0; rdEn = 0; wrEn = 0; wd32 = '0; wd64 = '0;
    priv = 2'b00; retire = 0; timeIn = '0;
    mCyc32 = '0; mIns32 = '0; mCyc64 = '0; mIns64 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: counters start at zero
    step(12'hB00, 1, 0, 32'h0, 2'b11, 0, "R1");
    step(12'hB02, 1, 0, 32'h0, 2'b11, 0, "R1");
    // R2: cycle keeps counting
    step(12'hB00, 1, 0, 32'h0, 2'b11, 0, "R2");
    // R3: retire pulses counted, holds otherwise
    for (int i = 0; i < 6; i++) step(12'hC02, 1, 0, 32'h0, 2'b00, i[0], "R3");
    // R4: low window writes
    step(12'hB00, 0, 1, 32'h1234_5678, 2'b11, 0, "R4");
    step(12'hB00, 1, 0, 32'h0, 2'b11, 0, "R4");
    // R6: write beats retire in same cycle
    step(12'hB02, 0, 1, 32'h0000_0100, 2'b11, 1, "R6");
    step(12'hB02, 1, 0, 32'h0, 2'b11, 1, "R6");
    // R5: high-half write leaves low half
    step(12'hB82, 0, 1, 32'hCAFE_0001, 2'b11, 0, "R5");
    step(12'hB82, 1, 1, 32'h0, 2'b01, 0, "R5");
    step(12'hB02, 1, 0, 32'h0, 2'b11, 0, "R5");
    // R2: wrap of all-ones cycle counter
    step(12'hB80, 0, 1, 32'hFFFF_FFFF, 2'b11, 0, "R2");
    step(12'hB00, 0, 1, 32'hFFFF_FFFF, 2'b11, 0, "R2");
    step(12'hB00, 1, 0, 32'h0, 2'b11, 0, "R2");
    step(12'hB80, 1, 0, 32'h0, 2'b11, 0, "R2");
    // R7: user aliases including time
    step(12'hC01, 1, 0, 32'h8765_4321, 2'b00, 0, "R7");
    step(12'hC81, 1, 0, 32'h0F0F_F0F0, 2'b00, 0, "R7");
    step(12'hC80, 1, 0, 32'h0, 2'b00, 0, "R7");
    // R9: alias write rejected, state visible afterwards
    step(12'hC02, 0, 1, 32'hDEAD_BEEF, 2'b00, 0, "R9");
    step(12'hC02, 1, 0, 32'h0, 2'b00, 0, "R9");

    // R8, R10: read sweep over every address and privilege encoding
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 4096; a++)
        step(a[11:0], 1, 0, a * 32'h9E37_79B9, p[1:0], a[2], "R8,R10");

    // R9, R10, R5, R6: write sweep, mixed with reads
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 4096; a++)
        step(a[11:0], a[0], 1, (a + p) * 32'h85EB_CA6B, p[1:0], a[1], "R9,R10");

    // Final readback after sweeps
    step(12'hB00, 1, 0, 32'h0, 2'b11, 0, "R4");
    step(12'hB82, 1, 0, 32'h0, 2'b11, 0, "R5");
    summary();
  end

endmodule